// File: doc/BRIEF.md
# Static Backward-Taken Next-PC Predictor

This block chooses the fetch address for the cycle after the current one. It looks at the 32-bit instruction word fetched at the current PC and sorts it into one of four kinds: conditional branch, direct jump, register jump, or other. A conditional branch whose displacement is negative, and every direct jump, is predicted taken. For these the target is formed by a dedicated adder in the fetch stage: the PC plus the sign-extended immediate. All other words, including register jumps, continue at the PC plus four. The block reports the predicted direction as a one-bit tag. The pipeline carries this tag with the branch address to the execute stage.

When the execute stage resolves a control instruction, it returns the actual direction and target, the recorded prediction and the instruction's PC. If the actual direction differs from the recorded one, the block raises a squash that turns the two younger instructions into bubbles. In the same cycle it supplies the corrected fetch address. That address is the target when the instruction was actually taken, and its PC plus four when it was not. A register jump is always recorded as not taken and always resolves taken, so it always redirects from execute. A direct jump's target is exact in fetch, so it never redirects.

Top module: `btfnt_npc`

## Requirements
- R1: A word is a conditional branch only when bits [6:0] equal 1100011 and bits [14:12] are one of 000, 001, 100, 101, 110, 111. Values 010 and 011 with that opcode are treated as ordinary instructions: next_pc = pc+4 and pred_taken = 0.
- R2: A conditional branch with instruction bit 31 set (negative displacement) gives pred_taken = 1 and next_pc = pc + sext({b31,b7,b30:25,b11:8,0}).
- R3: A conditional branch with bit 31 clear (zero or positive displacement) gives pred_taken = 0 and next_pc = pc+4.
- R4: A direct jump (bits [6:0] = 1101111) gives pred_taken = 1 and next_pc = pc + sext({b31,b19:12,b20,b30:21,0}), whatever the sign of the offset.
- R5: A register jump (bits [6:0] = 1100111) and every other opcode give pred_taken = 0 and next_pc = pc+4.
- R6: When ex_valid is 1 and ex_taken differs from ex_pred_taken, squash is 1 in the same cycle. next_pc is then ex_target if ex_taken is 1, and ex_pc+4 otherwise.
- R7: When ex_valid is 0, or ex_taken equals ex_pred_taken, squash is 0 and next_pc follows the fetch-stage prediction (the other EX inputs have no effect).
- R8: With stall = 1 and no redirect, next_pc equals pc. pred_taken still reflects the fetched word.
- R9: An EX redirect takes priority over both stall and the fetch-stage prediction.
- R10: All address arithmetic wraps modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (samples the embedded checks) |
| rst_n | input | 1 | Active-low reset (disables the embedded checks) |
| pc_i | input | XLEN | Address of the word being fetched |
| insn_i | input | 32 | Fetched instruction word |
| stall_i | input | 1 | Hold the fetch address |
| ex_valid_i | input | 1 | A control instruction is resolving in EX |
| ex_taken_i | input | 1 | Actual direction from EX |
| ex_pred_taken_i | input | 1 | Direction recorded at fetch for that instruction |
| ex_target_i | input | XLEN | Actual target computed in EX |
| ex_pc_i | input | XLEN | Address of the resolving instruction |
| next_pc_o | output | XLEN | Fetch address for the next cycle |
| pred_taken_o | output | 1 | Prediction tag for the fetched word |
| squash_o | output | 1 | Bubble the IF and ID instructions |

## Verification
A wrong classification appears in the same cycle as a mismatch of pred_taken and next_pc for the word on insn_i. A bad immediate shows only as a wrong next_pc on a predicted-taken word. The block holds no state, so every error is visible combinationally in the cycle its inputs are applied. The execute-side errors of interest are a missing or spurious squash, and a corrected address that picks the wrong one of target and pc+4. Each of these is exposed by driving both disagreement polarities and both agreement cases, with and without stall.

// File: rtl/btfnt_pkg.sv
package btfnt_pkg;

   localparam int unsigned WORD_W = 32;

   localparam logic [6:0] OPC_COND = 7'b1100011;
   localparam logic [6:0] OPC_JMP  = 7'b1101111;
   localparam logic [6:0] OPC_RJMP = 7'b1100111;

   typedef enum logic [1:0] {
      KIND_OTHER = 2'd0,
      KIND_COND  = 2'd1,
      KIND_JMP   = 2'd2,
      KIND_RJMP  = 2'd3
   } cf_kind_e;

   // funct3 codes 010 and 011 are not defined for the conditional opcode
   function automatic logic cond_funct_ok(input logic [2:0] f3);
      return (f3 != 3'b010) && (f3 != 3'b011);
   endfunction

endpackage

// File: rtl/btfnt_decode.sv
module btfnt_decode
   import btfnt_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [WORD_W-1:0] insn_i,
   output cf_kind_e          kind_o,
   output logic [XLEN-1:0]   disp_o
);

   localparam int unsigned BIMM_W = 13;
   localparam int unsigned JIMM_W = 21;

   logic [BIMM_W-1:0] bimm;
   logic [JIMM_W-1:0] jimm;
   logic [6:0]        opc;
   logic [2:0]        f3;

   assign opc  = insn_i[6:0];
   assign f3   = insn_i[14:12];
   assign bimm = {insn_i[31], insn_i[7], insn_i[30:25], insn_i[11:8], 1'b0};
   assign jimm = {insn_i[31], insn_i[19:12], insn_i[20], insn_i[30:21], 1'b0};

   always_comb begin
      kind_o = KIND_OTHER;
      unique case (opc)
         OPC_COND: kind_o = cond_funct_ok(f3) ? KIND_COND : KIND_OTHER;
         OPC_JMP:  kind_o = KIND_JMP;
         OPC_RJMP: kind_o = KIND_RJMP;
         default:  kind_o = KIND_OTHER;
      endcase
   end

   always_comb begin
      if (kind_o == KIND_JMP)
         disp_o = {{(XLEN-JIMM_W){jimm[JIMM_W-1]}}, jimm};
      else
         disp_o = {{(XLEN-BIMM_W){bimm[BIMM_W-1]}}, bimm};
   end

endmodule

// File: rtl/btfnt_redirect.sv
module btfnt_redirect #(
   parameter int unsigned XLEN = 32
) (
   input  logic            valid_i,
   input  logic            taken_i,
   input  logic            pred_i,
   input  logic [XLEN-1:0] target_i,
   input  logic [XLEN-1:0] pc_i,
   output logic            redirect_o,
   output logic [XLEN-1:0] fix_pc_o
);

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   assign redirect_o = valid_i && (taken_i != pred_i);
   assign fix_pc_o   = taken_i ? target_i : (pc_i + STEP);

endmodule

// File: rtl/btfnt_npc.sv
module btfnt_npc
   import btfnt_pkg::*;
#(
   parameter int unsigned XLEN          = 32,
   parameter bit          BACKWARD_TAKEN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [WORD_W-1:0] insn_i,
   input  logic              stall_i,
   input  logic              ex_valid_i,
   input  logic              ex_taken_i,
   input  logic              ex_pred_taken_i,
   input  logic [XLEN-1:0]   ex_target_i,
   input  logic [XLEN-1:0]   ex_pc_i,
   output logic [XLEN-1:0]   next_pc_o,
   output logic              pred_taken_o,
   output logic              squash_o
);

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   if (XLEN < 32) begin : g_bad_xlen
      $error("btfnt_npc: XLEN must be at least 32");
   end

   cf_kind_e        kind;
   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] tgt_pc;
   logic [XLEN-1:0] fix_pc;
   logic            redirect;
   logic            guess;

   btfnt_decode #(.XLEN(XLEN)) u_dec (
      .insn_i (insn_i),
      .kind_o (kind),
      .disp_o (disp)
   );

   btfnt_redirect #(.XLEN(XLEN)) u_fix (
      .valid_i    (ex_valid_i),
      .taken_i    (ex_taken_i),
      .pred_i     (ex_pred_taken_i),
      .target_i   (ex_target_i),
      .pc_i       (ex_pc_i),
      .redirect_o (redirect),
      .fix_pc_o   (fix_pc)
   );

   assign seq_pc = pc_i + STEP;
   assign tgt_pc = pc_i + disp;

   if (BACKWARD_TAKEN) begin : g_btfnt
      assign guess = (kind == KIND_JMP) || ((kind == KIND_COND) && disp[XLEN-1]);
   end else begin : g_not_taken
      assign guess = (kind == KIND_JMP);
   end

   always_comb begin
      if (redirect)
         next_pc_o = fix_pc;
      else if (stall_i)
         next_pc_o = pc_i;
      else if (guess)
         next_pc_o = tgt_pc;
      else
         next_pc_o = seq_pc;
   end

   assign pred_taken_o = guess;
   assign squash_o     = redirect;

   // R6: a squash always carries the corrected address
   p_squash_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      squash_o |-> (next_pc_o == (ex_taken_i ? ex_target_i : ex_pc_i + STEP)));

   // R7: agreement or an idle EX never squashes
   p_agree_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ex_valid_i || (ex_taken_i == ex_pred_taken_i)) |-> !squash_o);

   // R8: stall without redirect holds the fetch address
   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !squash_o) |-> (next_pc_o == pc_i));

   // R4: direct jumps are always guessed taken
   p_jump_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_i[6:0] == OPC_JMP) |-> pred_taken_o);

   // R5: register jumps are always fetched sequentially
   p_rjump_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_i[6:0] == OPC_RJMP && !stall_i && !squash_o) |->
         (!pred_taken_o && next_pc_o == pc_i + STEP));

   // R3: forward conditionals are not taken
   p_forward_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_i[6:0] == OPC_COND && !insn_i[31]) |-> !pred_taken_o);

endmodule

// File: tb/btfnt_npc_test.sv
module btfnt_npc_test;

   typedef struct packed {
      logic [3:0]  req;
      logic [31:0] pc;
      logic [31:0] insn;
      logic        stall;
      logic        exv;
      logic        ext;
      logic        expred;
      logic [31:0] extgt;
      logic [31:0] expc;
      logic [31:0] npc;
      logic        pred;
      logic        sq;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{4'd2,  32'h100, 32'hFE000CE3, 1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'h000000F8, 1'b1,1'b0}, // R2 beq -8
      '{4'd3,  32'h200, 32'h00001863, 1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'h00000204, 1'b0,1'b0}, // R3 bne +16
      '{4'd1,  32'h200, 32'hFE002CE3, 1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'h00000204, 1'b0,1'b0}, // R1 funct3 010
      '{4'd2,  32'h300, 32'hFE006CE3, 1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'h000002F8, 1'b1,1'b0}, // R2 bltu -8
      '{4'd4,  32'h1000,32'h001000EF, 1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'h00001800, 1'b1,1'b0}, // R4 jal +2048
      '{4'd4,  32'h1000,32'hFFDFF06F, 1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'h00000FFC, 1'b1,1'b0}, // R4 jal -4
      '{4'd5,  32'h1000,32'h00008067, 1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'h00001004, 1'b0,1'b0}, // R5 jalr
      '{4'd5,  32'h40,  32'h00100093, 1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'h00000044, 1'b0,1'b0}, // R5 addi
      '{4'd10, 32'hFFFFFFFC,32'h00100093,1'b0,1'b0,1'b0,1'b0,32'h0,  32'h0,    32'h00000000, 1'b0,1'b0}, // R10 wrap up
      '{4'd10, 32'h4,   32'hFE000CE3, 1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'hFFFFFFFC, 1'b1,1'b0}, // R10 wrap down
      '{4'd6,  32'h500, 32'hFE000CE3, 1'b0,1'b1,1'b1,1'b0, 32'h3000, 32'h2000, 32'h00003000, 1'b1,1'b1}, // R6 taken, guessed not
      '{4'd6,  32'h500, 32'h00100093, 1'b0,1'b1,1'b0,1'b1, 32'h1F00, 32'h2000, 32'h00002004, 1'b0,1'b1}, // R6 not taken, guessed taken
      '{4'd7,  32'h500, 32'hFE000CE3, 1'b0,1'b1,1'b1,1'b1, 32'h3000, 32'h2000, 32'h000004F8, 1'b1,1'b0}, // R7 agree
      '{4'd7,  32'h500, 32'h00100093, 1'b0,1'b0,1'b1,1'b0, 32'h3000, 32'h2000, 32'h00000504, 1'b0,1'b0}, // R7 idle EX
      '{4'd8,  32'h600, 32'hFE000CE3, 1'b1,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'h00000600, 1'b1,1'b0}, // R8 stall
      '{4'd9,  32'h600, 32'h001000EF, 1'b1,1'b1,1'b0,1'b1, 32'h0,    32'h700,  32'h00000704, 1'b1,1'b1}, // R9 redirect over stall
      '{4'd3,  32'h80,  32'h00000063, 1'b0,1'b0,1'b0,1'b0, 32'h0,    32'h0,    32'h00000084, 1'b0,1'b0}  // R3 zero disp
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_i = '0;
   logic [31:0] insn_i = '0;
   logic        stall_i = 1'b0;
   logic        ex_valid_i = 1'b0;
   logic        ex_taken_i = 1'b0;
   logic        ex_pred_taken_i = 1'b0;
   logic [31:0] ex_target_i = '0;
   logic [31:0] ex_pc_i = '0;
   logic [31:0] next_pc_o;
   logic        pred_taken_o;
   logic        squash_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   btfnt_npc uut (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .insn_i(insn_i), .stall_i(stall_i),
      .ex_valid_i(ex_valid_i), .ex_taken_i(ex_taken_i), .ex_pred_taken_i(ex_pred_taken_i),
      .ex_target_i(ex_target_i), .ex_pc_i(ex_pc_i),
      .next_pc_o(next_pc_o), .pred_taken_o(pred_taken_o), .squash_o(squash_o)
   );

   task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL R0 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // reset state: idle inputs, no squash, sequential address (R7, R5)
      repeat (2) @(negedge clk);
      #2;
      check(7, "reset squash", {31'd0, squash_o}, 32'd0);
      check(5, "reset next_pc", next_pc_o, 32'h4);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         pc_i = VECS[i].pc;          insn_i = VECS[i].insn;
         stall_i = VECS[i].stall;    ex_valid_i = VECS[i].exv;
         ex_taken_i = VECS[i].ext;   ex_pred_taken_i = VECS[i].expred;
         ex_target_i = VECS[i].extgt; ex_pc_i = VECS[i].expc;
         #2;
         check(int'(VECS[i].req), "next_pc", next_pc_o, VECS[i].npc);
         check(int'(VECS[i].req), "pred_taken", {31'd0, pred_taken_o}, {31'd0, VECS[i].pred});
         check(int'(VECS[i].req), "squash", {31'd0, squash_o}, {31'd0, VECS[i].sq});
      end

      // R1: sweep funct3 on a backward conditional word
      stall_i = 1'b0; ex_valid_i = 1'b0;
      for (int f = 0; f < 8; f++) begin
         @(negedge clk);
         pc_i = 32'h800;
         insn_i = 32'hFE000CE3 | (32'(f) << 12);
         #2;
         if (f == 2 || f == 3) begin
            check(1, "funct3 pred", {31'd0, pred_taken_o}, 32'd0);
            check(1, "funct3 next_pc", next_pc_o, 32'h804);
         end else begin
            check(1, "funct3 pred", {31'd0, pred_taken_o}, 32'd1);
            check(1, "funct3 next_pc", next_pc_o, 32'h7F8);
         end
      end

      // R5: register jump with negative offset still sequential
      @(negedge clk);
      pc_i = 32'h900; insn_i = 32'hFF808067;
      #2;
      check(5, "jalr neg pred", {31'd0, pred_taken_o}, 32'd0);
      check(5, "jalr neg next_pc", next_pc_o, 32'h904);

      // R9: redirect overrides a backward-taken guess without stall
      @(negedge clk);
      pc_i = 32'hA00; insn_i = 32'hFE000CE3;
      ex_valid_i = 1'b1; ex_taken_i = 1'b0; ex_pred_taken_i = 1'b1; ex_pc_i = 32'hB00;
      #2;
      check(9, "override next_pc", next_pc_o, 32'hB04);
      check(9, "override squash", {31'd0, squash_o}, 32'd1);

      @(negedge clk);
      ex_valid_i = 1'b0;
      finish_run();
   end

endmodule